// File: doc/BRIEF.md
# JTAG Debug Transport Module

This block sits behind a chip's JTAG pins and gives an external debugger a path into an on-chip debug module. A 16-state test access port controller follows TMS on rising TCK. A 5-bit instruction register picks one of four data registers: a 32-bit identification word, a 32-bit transport control/status word, a 41-bit debug-module access word, or a 1-bit bypass. Each scan shifts least-significant bit first, with TDI entering at the top of the selected register.

The JTAG pins are oversampled in the system clock domain through a short synchronizer chain, so the whole block runs on `clk`. When an Update-DR of the access word carries a read or write operation, the block hands a request to the debug module. The request port is valid/ready. `dmi_req_valid` rises with the address, data and operation and holds them unchanged until `dmi_req_ready` is seen high at a clock edge. Then `dmi_rsp_ready` rises and stays high until a `dmi_rsp_valid` beat is taken. The block raises no new request until that response arrives, so the debug module may stall either channel for as long as it needs. The response word is kept and shown by the next Capture-DR of the access word.

An access attempted while the previous one is still open is dropped and sets a sticky error. A flag in the control/status word clears it. Test-Logic-Reset abandons any open access.

Top module: `jtag_dtm`

## Requirements
- R1: Reset, a low `jtag_trst_n`, or five rising TCK edges with TMS high put the controller in Test-Logic-Reset. Test-Logic-Reset loads instruction code 00001, so a data scan that follows without an instruction scan returns the identification word.
- R2: The instruction register is 5 bits. Capture-IR loads 00001, and the new code takes effect at Update-IR.
- R3: Code 00001 selects the identification word, 10000 selects the control/status word and 10001 selects the access word. Every other code selects a 1-bit bypass that captures 0.
- R4: The identification word is {4'h0 version, 16'h0 part, 11-bit manufacturer parameter, 1'b1}.
- R5: The control/status word captures version 1 in bits 3:0, the address width in bits 9:4, and an error/busy status in bits 11:10 (3 when the sticky error is set, otherwise 0). All other bits capture 0.
- R6: The access word holds the address in bits 40:34, data in bits 33:2 and the operation in bits 1:0 (00 none, 01 read, 10 write, 11 treated as none). At Update-DR, read and write issue exactly one request that carries these fields. 00 and 11 issue nothing.
- R7: `dmi_req_valid` stays high, with address, data and operation unchanged, until a clock edge on which `dmi_req_ready` is high.
- R8: `dmi_rsp_ready` is high only after the request has been accepted and until the response has been taken. The next capture of the access word returns {last address, response data, 00}.
- R9: A read or write update while an access is open is dropped and sets the sticky error. The access word captures status 11 while an access is open or the sticky error is set.
- R10: An Update-DR of the control/status word with bit 16 set clears the sticky error.
- R11: TDO changes only after a falling TCK and shows bit 0 of the register being shifted. The shift length equals the selected register's width.
- R12: Test-Logic-Reset drops a pending request and clears the open-access and sticky-error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the JTAG pins |
| rst_n | input | 1 | Active-low synchronous reset |
| jtag_tck | input | 1 | Test clock (oversampled) |
| jtag_tms | input | 1 | Test mode select |
| jtag_tdi | input | 1 | Test data in |
| jtag_trst_n | input | 1 | Active-low test reset |
| jtag_tdo | output | 1 | Test data out |
| dmi_req_valid | output | 1 | Request valid |
| dmi_req_ready | input | 1 | Request accepted when high with valid |
| dmi_req_addr | output | ABITS | Request address |
| dmi_req_data | output | 32 | Request write data |
| dmi_req_op | output | 2 | Request operation, 01 read, 10 write |
| dmi_rsp_valid | input | 1 | Response valid |
| dmi_rsp_ready | output | 1 | Response accepted when high with valid |
| dmi_rsp_data | input | 32 | Response data |

## Verification
The bench builds the block with its default address width of 7, a two-stage synchronizer and a manufacturer field of 11'h5A3. With those values every one of the 32 instruction codes can be swept and every data register scanned end to end. The expected capture image, including the ones that spill out past a register's length, is computed arithmetically. The bench's debug-module model can withhold ready and delay responses. This reaches the back-pressure hold, the busy status, the dropped overlapping access, sticky-error clearing and reset abandonment of a stalled request.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int IR_W   = 5;
  localparam int DATA_W = 32;

  localparam logic [IR_W-1:0] IR_IDCODE = 5'b00001;
  localparam logic [IR_W-1:0] IR_CTRL   = 5'b10000;
  localparam logic [IR_W-1:0] IR_ACCESS = 5'b10001;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } dmi_op_e;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    DR_BYPASS, DR_IDCODE, DR_CTRL, DR_ACCESS
  } dr_sel_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

  function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] ir);
    dr_sel_e d;
    case (ir)
      IR_IDCODE: d = DR_IDCODE;
      IR_CTRL:   d = DR_CTRL;
      IR_ACCESS: d = DR_ACCESS;
      default:   d = DR_BYPASS;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/jtag_pin_sync.sv
module jtag_pin_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import dtm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tck_rise,
  input  logic       tms,
  input  logic       trst,
  output tap_state_e state
);
  always_ff @(posedge clk) begin
    if (!rst_n)        state <= ST_RESET;
    else if (trst)     state <= ST_RESET;
    else if (tck_rise) state <= tap_next(state, tms);
  end

  AST_TAP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!tck_rise && !trst) |=> $stable(state));  // R1
  AST_TMS_HOLD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET && tck_rise && tms) |=> state == ST_RESET);  // R1
  AST_TRST_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    trst |=> state == ST_RESET);  // R1
endmodule

// File: rtl/dtm_dmi_port.sv
module dtm_dmi_port
  import dtm_pkg::*;
#(
  parameter int ABITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              issue,
  input  logic [ABITS-1:0]  issue_addr,
  input  logic [DATA_W-1:0] issue_data,
  input  logic [1:0]        issue_op,
  output logic              busy,
  output logic [ABITS-1:0]  last_addr,
  output logic [DATA_W-1:0] last_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ABITS-1:0]  req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        req_op,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data
);
  logic              pend_q;
  logic              wait_q;
  logic [ABITS-1:0]  addr_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        op_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      wait_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      op_q    <= OP_NOP;
      rdata_q <= '0;
    end else if (clear) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (issue) begin
        pend_q <= 1'b1;
        addr_q <= issue_addr;
        data_q <= issue_data;
        op_q   <= issue_op;
      end else if (pend_q && req_ready) begin
        pend_q <= 1'b0;
        wait_q <= 1'b1;
      end
      if (wait_q && rsp_valid) begin
        wait_q  <= 1'b0;
        rdata_q <= rsp_data;
      end
    end
  end

  assign busy       = pend_q | wait_q;
  assign last_addr  = addr_q;
  assign last_rdata = rdata_q;
  assign req_valid  = pend_q;
  assign req_addr   = addr_q;
  assign req_data   = data_q;
  assign req_op     = op_q;
  assign rsp_ready  = wait_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !clear) |=>
      (req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_op)));  // R7
  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_op == OP_READ || req_op == OP_WRITE));  // R6
  AST_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !(req_valid || rsp_ready));  // R9
  AST_RSP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid);  // R8
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!req_valid && !rsp_ready));  // R12
endmodule

// File: rtl/dtm_scan_regs.sv
module dtm_scan_regs
  import dtm_pkg::*;
#(
  parameter int          ABITS  = 7,
  parameter logic [10:0] MFR_ID = 11'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  logic              tck_rise,
  input  logic              tck_fall,
  input  logic              tdi,
  output logic              tdo,
  input  logic              busy,
  input  logic [ABITS-1:0]  last_addr,
  input  logic [DATA_W-1:0] last_rdata,
  output logic              issue,
  output logic [ABITS-1:0]  issue_addr,
  output logic [DATA_W-1:0] issue_data,
  output logic [1:0]        issue_op
);
  localparam int ACC_W   = ABITS + DATA_W + 2;
  localparam int CLR_BIT = 16;

  logic [IR_W-1:0]  ir_q;
  logic [IR_W-1:0]  ir_sh_q;
  logic [ACC_W-1:0] dr_q;
  logic             sticky_q;
  logic             tdo_q;
  dr_sel_e          sel;
  logic [1:0]       op_status;
  logic [31:0]      id_word;
  logic [31:0]      ctrl_word;
  logic [ACC_W-1:0] acc_word;
  logic             upd_dr;
  logic             acc_op_valid;
  logic             in_reset;

  assign sel       = dr_decode(ir_q);
  assign in_reset  = (state == ST_RESET);
  assign op_status = (busy || sticky_q) ? 2'b11 : 2'b00;
  assign id_word   = {4'h0, 16'h0000, MFR_ID, 1'b1};
  assign ctrl_word = {17'b0, 3'b000, (sticky_q ? 2'b11 : 2'b00), 6'(ABITS), 4'd1};
  assign acc_word  = {last_addr, last_rdata, op_status};

  assign issue_addr   = dr_q[ACC_W-1 -: ABITS];
  assign issue_data   = dr_q[DATA_W+1:2];
  assign issue_op     = dr_q[1:0];
  assign acc_op_valid = (issue_op == OP_READ) || (issue_op == OP_WRITE);
  assign upd_dr       = tck_rise && (state == ST_UPD_DR);
  assign issue        = upd_dr && (sel == DR_ACCESS) && acc_op_valid && !busy;

  // instruction path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q    <= IR_IDCODE;
      ir_sh_q <= '0;
    end else if (in_reset) begin
      ir_q <= IR_IDCODE;
    end else if (tck_rise) begin
      case (state)
        ST_CAP_IR: ir_sh_q <= 5'b00001;
        ST_SHF_IR: ir_sh_q <= {tdi, ir_sh_q[IR_W-1:1]};
        ST_UPD_IR: ir_q    <= ir_sh_q;
        default: ;
      endcase
    end
  end

  // data path: one shift register shared by every data register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q <= '0;
    end else if (tck_rise) begin
      if (state == ST_CAP_DR) begin
        case (sel)
          DR_IDCODE: dr_q <= ACC_W'(id_word);
          DR_CTRL:   dr_q <= ACC_W'(ctrl_word);
          DR_ACCESS: dr_q <= acc_word;
          default:   dr_q <= '0;
        endcase
      end else if (state == ST_SHF_DR) begin
        case (sel)
          DR_ACCESS: dr_q        <= {tdi, dr_q[ACC_W-1:1]};
          DR_IDCODE,
          DR_CTRL:   dr_q[31:0]  <= {tdi, dr_q[31:1]};
          default:   dr_q[0]     <= tdi;
        endcase
      end
    end
  end

  // sticky error for overlapping accesses
  always_ff @(posedge clk) begin
    if (!rst_n || in_reset) begin
      sticky_q <= 1'b0;
    end else if (upd_dr) begin
      if (sel == DR_ACCESS && acc_op_valid && busy) sticky_q <= 1'b1;
      else if (sel == DR_CTRL && dr_q[CLR_BIT])     sticky_q <= 1'b0;
    end
  end

  // TDO launched on falling TCK
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
    end else if (tck_fall) begin
      if (state == ST_SHF_DR)      tdo_q <= dr_q[0];
      else if (state == ST_SHF_IR) tdo_q <= ir_sh_q[0];
      else                         tdo_q <= 1'b0;
    end
  end
  assign tdo = tdo_q;

  AST_TDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !tck_fall |=> $stable(tdo));  // R11
  AST_RESET_IR: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |=> ir_q == IR_IDCODE);  // R1
  AST_RESET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |=> !sticky_q);  // R12
  AST_OVERLAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_dr && sel == DR_ACCESS && acc_op_valid && busy) |=> sticky_q);  // R9
endmodule

// File: rtl/jtag_dtm.sv
module jtag_dtm
  import dtm_pkg::*;
#(
  parameter int          ABITS       = 7,
  parameter int          SYNC_STAGES = 2,
  parameter logic [10:0] MFR_ID      = 11'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jtag_tck,
  input  logic              jtag_tms,
  input  logic              jtag_tdi,
  input  logic              jtag_trst_n,
  output logic              jtag_tdo,
  output logic              dmi_req_valid,
  input  logic              dmi_req_ready,
  output logic [ABITS-1:0]  dmi_req_addr,
  output logic [DATA_W-1:0] dmi_req_data,
  output logic [1:0]        dmi_req_op,
  input  logic              dmi_rsp_valid,
  output logic              dmi_rsp_ready,
  input  logic [DATA_W-1:0] dmi_rsp_data
);
  logic [3:0]        pins_s;
  logic              tck_s, tms_s, tdi_s, trst_s;
  logic              tck_prev_q;
  logic              tck_rise, tck_fall;
  tap_state_e        state;
  logic              busy, issue;
  logic [ABITS-1:0]  last_addr, issue_addr;
  logic [DATA_W-1:0] last_rdata, issue_data;
  logic [1:0]        issue_op;

  jtag_pin_sync #(
    .STAGES (SYNC_STAGES),
    .W      (4),
    .RST_VAL(4'b1000)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({jtag_trst_n, jtag_tck, jtag_tms, jtag_tdi}),
    .q    (pins_s)
  );

  assign trst_s = !pins_s[3];
  assign tck_s  = pins_s[2];
  assign tms_s  = pins_s[1];
  assign tdi_s  = pins_s[0];

  always_ff @(posedge clk) begin
    if (!rst_n) tck_prev_q <= 1'b0;
    else        tck_prev_q <= tck_s;
  end
  assign tck_rise = tck_s && !tck_prev_q;
  assign tck_fall = !tck_s && tck_prev_q;

  jtag_tap_ctrl u_tap (
    .clk     (clk),
    .rst_n   (rst_n),
    .tck_rise(tck_rise),
    .tms     (tms_s),
    .trst    (trst_s),
    .state   (state)
  );

  dtm_scan_regs #(
    .ABITS (ABITS),
    .MFR_ID(MFR_ID)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .tck_rise  (tck_rise),
    .tck_fall  (tck_fall),
    .tdi       (tdi_s),
    .tdo       (jtag_tdo),
    .busy      (busy),
    .last_addr (last_addr),
    .last_rdata(last_rdata),
    .issue     (issue),
    .issue_addr(issue_addr),
    .issue_data(issue_data),
    .issue_op  (issue_op)
  );

  dtm_dmi_port #(
    .ABITS(ABITS)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (state == ST_RESET),
    .issue     (issue),
    .issue_addr(issue_addr),
    .issue_data(issue_data),
    .issue_op  (issue_op),
    .busy      (busy),
    .last_addr (last_addr),
    .last_rdata(last_rdata),
    .req_valid (dmi_req_valid),
    .req_ready (dmi_req_ready),
    .req_addr  (dmi_req_addr),
    .req_data  (dmi_req_data),
    .req_op    (dmi_req_op),
    .rsp_valid (dmi_rsp_valid),
    .rsp_ready (dmi_rsp_ready),
    .rsp_data  (dmi_rsp_data)
  );
endmodule

// File: tb/sim_jtag_dtm.sv
`timescale 1ns/1ps
module sim_jtag_dtm;
  localparam logic [10:0] MFR = 11'h5A3;
  localparam logic [31:0] IDW = {20'h0, MFR, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b1;
  logic tdo;
  logic req_valid, req_ready, rsp_valid, rsp_ready;
  logic [6:0]  req_addr;
  logic [31:0] req_data, rsp_data;
  logic [1:0]  req_op;

  logic ready_en = 1'b1, rsp_hold = 1'b0;
  logic pend;
  logic [31:0] pend_data;
  int hs_cnt;
  logic [6:0]  m_addr;
  logic [1:0]  m_op;
  logic [31:0] m_data;
  int n_chk = 0, n_fail = 0, glitch = 0;

  always #5 clk = ~clk;

  jtag_dtm #(.ABITS(7), .SYNC_STAGES(2), .MFR_ID(MFR)) u0 (
    .clk(clk), .rst_n(rst_n), .jtag_tck(tck), .jtag_tms(tms), .jtag_tdi(tdi),
    .jtag_trst_n(trst_n), .jtag_tdo(tdo),
    .dmi_req_valid(req_valid), .dmi_req_ready(req_ready), .dmi_req_addr(req_addr),
    .dmi_req_data(req_data), .dmi_req_op(req_op),
    .dmi_rsp_valid(rsp_valid), .dmi_rsp_ready(rsp_ready), .dmi_rsp_data(rsp_data)
  );

  assign req_ready = ready_en;

  // debug-module model
  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_data <= '0; pend <= 1'b0; pend_data <= '0;
      hs_cnt <= 0; m_addr <= '0; m_op <= '0; m_data <= '0;
    end else begin
      if (req_valid && req_ready) begin
        hs_cnt <= hs_cnt + 1;
        m_addr <= req_addr; m_op <= req_op; m_data <= req_data;
        pend <= 1'b1;
        pend_data <= (req_op == 2'b10) ? req_data : (32'hA500_0000 | (32'(req_addr) * 32'h101));
      end
      if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0; pend <= 1'b0;
      end else if (pend && !rsp_hold && !rsp_valid) begin
        rsp_valid <= 1'b1; rsp_data <= pend_data;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    logic hi;
    @(negedge clk); tck = 1'b0; tms = m; tdi = d;
    idle(6); o = tdo;
    tck = 1'b1;
    idle(6); hi = tdo;
    if (hi !== o) glitch++;
  endtask

  task automatic tap_reset();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic shift_ir(input logic [4:0] code, output logic [4:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, code[i], o); cap[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic shift_dr(input logic [40:0] din, input int len, output logic [40:0] dout);
    logic o;
    dout = '1;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], o); dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  function automatic logic [40:0] acc(input logic [6:0] a, input logic [31:0] d, input logic [1:0] op);
    return {a, d, op};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [4:0]  irc;
    logic [40:0] o41, e41;
    logic [6:0]  a0;
    idle(4); rst_n = 1'b1; idle(4);
    // reset state
    chk("R1 reset outputs", {61'b0, tdo, req_valid, rsp_ready}, 64'd0);

    tap_reset();
    shift_dr('1, 32, o41);
    chk("R1 R4 idcode without ir scan", 64'(o41[31:0]), 64'(IDW));

    // sweep every instruction code
    for (int c = 0; c < 32; c++) begin
      int len;
      logic [40:0] cap;
      shift_ir(5'(c), irc);
      chk("R2 capture-ir value", 64'(irc), 64'd1);
      case (c)
        1:  begin len = 32; cap = 41'(IDW); end
        16: begin len = 32; cap = 41'h71; end
        17: begin len = 41; cap = '0; end
        default: begin len = 1; cap = '0; end
      endcase
      e41 = cap | ({41{1'b1}} << len);
      shift_dr('1, 41, o41);
      chk($sformatf("R3 R4 R5 R11 code %0d capture image", c), 64'(o41), 64'(e41));
    end
    chk("R6 op 11 issues nothing", 64'(hs_cnt), 64'd0);

    // write access
    shift_ir(5'b10001, irc);
    shift_dr(acc(7'h15, 32'hCAFEF00D, 2'b10), 41, o41);
    idle(40);
    chk("R6 R7 write request fields", {23'(hs_cnt), m_addr, m_op, m_data}, {23'd1, 7'h15, 2'b10, 32'hCAFEF00D});
    shift_dr(acc(0, 0, 2'b00), 41, o41);
    chk("R8 capture after write", 64'(o41), 64'(acc(7'h15, 32'hCAFEF00D, 2'b00)));
    chk("R6 op 00 issues nothing", 64'(hs_cnt), 64'd1);

    // read with delayed response
    rsp_hold = 1'b1;
    shift_dr(acc(7'h22, 0, 2'b01), 41, o41);
    idle(40);
    chk("R8 waiting for response", {62'b0, rsp_ready, req_valid}, 64'd2);
    shift_dr(acc(0, 0, 2'b00), 41, o41);
    chk("R9 busy status while open", 64'(o41[1:0]), 64'd3);
    rsp_hold = 1'b0; idle(40);
    chk("R8 rsp_ready drops after response", 64'(rsp_ready), 64'd0);
    shift_dr(acc(0, 0, 2'b00), 41, o41);
    chk("R8 read data captured", 64'(o41), 64'(acc(7'h22, 32'hA5002222, 2'b00)));

    // back-pressure and overlapping access
    ready_en = 1'b0;
    shift_dr(acc(7'h11, 0, 2'b01), 41, o41);
    idle(30); a0 = req_addr;
    chk("R7 request held", {55'b0, req_valid, req_addr, req_op[0]}, {55'b0, 1'b1, 7'h11, 1'b1});
    idle(30);
    chk("R7 payload stable", {56'b0, req_valid, req_addr}, {56'b0, 1'b1, a0});
    shift_dr(acc(7'h33, 0, 2'b01), 41, o41);
    chk("R9 capture while pending", 64'(o41[1:0]), 64'd3);
    ready_en = 1'b1; idle(40);
    chk("R9 overlapping access dropped", {23'(hs_cnt), m_addr, 34'b0}, {23'd3, 7'h11, 34'b0});
    shift_dr(acc(0, 0, 2'b00), 41, o41);
    chk("R9 sticky status", 64'(o41), 64'(acc(7'h11, 32'hA5001111, 2'b11)));
    shift_ir(5'b10000, irc);
    shift_dr(41'h1_0000, 32, o41);
    chk("R5 ctrl word with error", 64'(o41[31:0]), 64'h0C71);
    shift_dr('0, 32, o41);
    chk("R10 error cleared", 64'(o41[31:0]), 64'h0071);
    shift_ir(5'b10001, irc);
    shift_dr(acc(0, 0, 2'b00), 41, o41);
    chk("R10 access status clear", 64'(o41), 64'(acc(7'h11, 32'hA5001111, 2'b00)));

    // reset abandons a stalled request
    ready_en = 1'b0;
    shift_dr(acc(7'h40, 32'h12345678, 2'b10), 41, o41);
    idle(20);
    chk("R7 stalled write pending", 64'(req_valid), 64'd1);
    tap_reset();
    chk("R12 request dropped", {62'b0, req_valid, rsp_ready}, 64'd0);
    shift_dr('1, 32, o41);
    chk("R1 idcode after tms reset", 64'(o41[31:0]), 64'(IDW));
    ready_en = 1'b1; idle(20);
    chk("R12 no handshake after reset", 64'(hs_cnt), 64'd3);
    shift_ir(5'b10001, irc);
    shift_dr(acc(0, 0, 2'b00), 41, o41);
    chk("R12 access idle after reset", 64'(o41), 64'(acc(7'h40, 32'hA5001111, 2'b00)));

    // test reset pin
    shift_ir(5'b10000, irc);
    trst_n = 1'b0; idle(10); trst_n = 1'b1; idle(10);
    begin logic o; step(0, 0, o); end
    shift_dr('1, 32, o41);
    chk("R1 idcode after trst", 64'(o41[31:0]), 64'(IDW));

    chk("R11 tdo steady through high tck", 64'(glitch), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule